// File: doc/BRIEF.md
# Four-Lane Registered Sorting Network

This block orders four unsigned words from largest to smallest. A set of four inputs is registered on a rising clock edge. It passes through a fixed three-level network of five compare-exchange cells, and the ordered set is registered on the following edge. A new set can be presented on every cycle, so one sorted set leaves the block per clock after a two-edge fill.

Each compare-exchange cell does not use a magnitude comparator. It subtracts its second operand from its first with a chain of one-bit borrow slices, least significant bit first. The borrow leaving the top slice is set exactly when the first operand is the smaller one. That borrow steers the larger value to the cell's high output and the smaller value to its low output. When the two operands are equal, the cell does not swap them.

Top module: `psort4`

## Requirements
- R1: The inputs present at rising edge k appear, sorted, on the outputs after rising edge k+1. The outputs keep their previous values between edge k and edge k+1.
- R2: After every edge, `out_hi` >= `out_mh` >= `out_ml` >= `out_lo` as unsigned numbers.
- R3: The four outputs are a permutation of the four inputs captured one edge earlier. Duplicate values appear as many times as they were supplied.
- R4: While `rst` is high at a rising edge, both register stages are cleared to zero. The first result after `rst` falls is the sort of an all-zero set, which is all zeros.
- R5: Each cell's swap decision is the borrow out of its most significant slice. Bit i of a slice result is a XOR b XOR borrow-in. The borrow into bit 0 is 0. The cell swaps exactly when a < b unsigned, so operands that differ only by a carry across all bits (for example 7 and 8) are ordered correctly.
- R6: A cell whose operands are equal reports no swap. Sets with repeated values, including all four equal, come out intact.
- R7: A different set may be applied on every cycle. Each result depends only on its own set, with no carry-over from the set before or after it.
- R8: The extreme codes 0 and 2^W-1 are ordered correctly in every lane position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in0 | input | W | Unsorted word, lane 0 |
| in1 | input | W | Unsorted word, lane 1 |
| in2 | input | W | Unsorted word, lane 2 |
| in3 | input | W | Unsorted word, lane 3 |
| out_hi | output | W | Largest word of the set |
| out_mh | output | W | Second largest word |
| out_ml | output | W | Third largest word |
| out_lo | output | W | Smallest word |

## Verification
Capturing a new input set and registering the previous set's result happen on the same edge in every cycle. A streaming test drives a distinct set on each falling edge. At the same falling edge it compares the outputs with the reference sort of the set applied two falling edges earlier, so any mixing between neighbouring sets shows up as a miscompare. A second coincidence is a reset asserted in the middle of a stream. The test checks that the outputs drop to zero on the next edge, and that the first result after release is the all-zero set rather than stale data. Assertions check the descending order, the conservation of the sum and of the extremes across the two-edge latency, and the agreement between each cell's borrow and its operands on every cycle.

// File: rtl/sort_pkg.sv
`timescale 1ns/1ps
package sort_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned CELLS = 5;

  // one-bit subtract slice: a - bin - b
  function automatic logic slice_diff(input logic a, input logic b, input logic bin);
    return a ^ b ^ bin;
  endfunction

  function automatic logic slice_borrow(input logic a, input logic b, input logic bin);
    return (~a & b) | (~a & bin) | (b & bin);
  endfunction
endpackage

// File: rtl/borrow_slice.sv
`timescale 1ns/1ps
module borrow_slice
  import sort_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic bin,
  output logic r,
  output logic bout
);
  assign r    = slice_diff(a, b, bin);
  assign bout = slice_borrow(a, b, bin);
endmodule

// File: rtl/ripple_sub.sv
`timescale 1ns/1ps
module ripple_sub #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff,
  output logic         borrow_out
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    borrow_slice u_slice (
      .a   (a[i]),
      .b   (b[i]),
      .bin (chain[i]),
      .r   (diff[i]),
      .bout(chain[i+1])
    );
  end

  assign borrow_out = chain[W];
endmodule

// File: rtl/cmp_xchg.sv
`timescale 1ns/1ps
module cmp_xchg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic [W-1:0] gap,
  output logic         swap
);
  ripple_sub #(.W(W)) u_sub (
    .a         (a),
    .b         (b),
    .diff      (gap),
    .borrow_out(swap)
  );

  // borrow set means a < b: route b upward; ties keep order
  assign hi = swap ? b : a;
  assign lo = swap ? a : b;
endmodule

// File: rtl/psort4.sv
`timescale 1ns/1ps
module psort4
  import sort_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  output logic [W-1:0] out_hi,
  output logic [W-1:0] out_mh,
  output logic [W-1:0] out_ml,
  output logic [W-1:0] out_lo
);
  logic [LANES-1:0][W-1:0] cap_q;
  logic [LANES-1:0][W-1:0] res_q;
  logic [LANES-1:0][W-1:0] net_out;

  logic [CELLS-1:0][W-1:0] cx_a, cx_b, cx_hi, cx_lo, cx_gap;
  logic [CELLS-1:0]        cx_swap;

  // input capture stage
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= {in3, in2, in1, in0};
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    cmp_xchg #(.W(W)) u_cx (
      .a   (cx_a[g]),
      .b   (cx_b[g]),
      .hi  (cx_hi[g]),
      .lo  (cx_lo[g]),
      .gap (cx_gap[g]),
      .swap(cx_swap[g])
    );
  end

  // level 1: pairs (0,1) and (2,3)
  assign cx_a[0] = cap_q[0];
  assign cx_b[0] = cap_q[1];
  assign cx_a[1] = cap_q[2];
  assign cx_b[1] = cap_q[3];
  // level 2: the two winners meet, the two losers meet
  assign cx_a[2] = cx_hi[0];
  assign cx_b[2] = cx_hi[1];
  assign cx_a[3] = cx_lo[0];
  assign cx_b[3] = cx_lo[1];
  // level 3: settle the middle pair
  assign cx_a[4] = cx_hi[3];
  assign cx_b[4] = cx_lo[2];

  assign net_out[0] = cx_hi[2];
  assign net_out[1] = cx_hi[4];
  assign net_out[2] = cx_lo[4];
  assign net_out[3] = cx_lo[3];

  // result stage
  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= net_out;
  end

  assign out_hi = res_q[0];
  assign out_mh = res_q[1];
  assign out_ml = res_q[2];
  assign out_lo = res_q[3];
endmodule

module psort4_chk
  import sort_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [W-1:0]            in0,
  input logic [W-1:0]            in1,
  input logic [W-1:0]            in2,
  input logic [W-1:0]            in3,
  input logic [W-1:0]            out_hi,
  input logic [W-1:0]            out_mh,
  input logic [W-1:0]            out_ml,
  input logic [W-1:0]            out_lo,
  input logic [CELLS-1:0][W-1:0] cx_a,
  input logic [CELLS-1:0][W-1:0] cx_b,
  input logic [CELLS-1:0][W-1:0] cx_gap,
  input logic [CELLS-1:0]        cx_swap
);
  logic [W+1:0] in_sum, out_sum;
  logic [W-1:0] in_max, in_min;
  logic [1:0]   warm = 2'd0;
  logic         rst_seen = 1'b0;

  assign in_sum  = (W+2)'(in0) + (W+2)'(in1) + (W+2)'(in2) + (W+2)'(in3);
  assign out_sum = (W+2)'(out_hi) + (W+2)'(out_mh) + (W+2)'(out_ml) + (W+2)'(out_lo);

  always_comb begin
    in_max = in0; in_min = in0;
    if (in1 > in_max) in_max = in1;
    if (in2 > in_max) in_max = in2;
    if (in3 > in_max) in_max = in3;
    if (in1 < in_min) in_min = in1;
    if (in2 < in_min) in_min = in2;
    if (in3 < in_min) in_min = in3;
  end

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R4
  always_ff @(posedge clk) begin
    if (rst_seen)
      reset_clear_chk: assert (out_hi == '0 && out_mh == '0 && out_ml == '0 && out_lo == '0);
  end

  // R2
  order_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (out_hi >= out_mh) && (out_mh >= out_ml) && (out_ml >= out_lo));

  // R3
  sum_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_sum == $past(in_sum, 2)));

  // R1
  extreme_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_hi == $past(in_max, 2) && out_lo == $past(in_min, 2)));

  for (genvar g = 0; g < CELLS; g++) begin : g_cell_chk
    // R5
    borrow_rule_chk: assert property (@(posedge clk) disable iff (rst)
      cx_swap[g] == (cx_a[g] < cx_b[g]));
    // R5
    gap_value_chk: assert property (@(posedge clk) disable iff (rst)
      cx_gap[g] == W'(cx_a[g] - cx_b[g]));
    // R6
    tie_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (cx_a[g] == cx_b[g]) |-> !cx_swap[g]);
  end
endmodule

bind psort4 psort4_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in0    (in0),
  .in1    (in1),
  .in2    (in2),
  .in3    (in3),
  .out_hi (out_hi),
  .out_mh (out_mh),
  .out_ml (out_ml),
  .out_lo (out_lo),
  .cx_a   (cx_a),
  .cx_b   (cx_b),
  .cx_gap (cx_gap),
  .cx_swap(cx_swap)
);

// File: tb/psort4_bench.sv
`timescale 1ns/1ps
module psort4_bench;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] i0 = '0, i1 = '0, i2 = '0, i3 = '0;
  logic [W-1:0] o_hi, o_mh, o_ml, o_lo;
  int applied = 0;
  int bad = 0;

  always #2 clk = ~clk;

  psort4 #(.W(W)) u_psort4 (
    .clk(clk), .rst(rst),
    .in0(i0), .in1(i1), .in2(i2), .in3(i3),
    .out_hi(o_hi), .out_mh(o_mh), .out_ml(o_ml), .out_lo(o_lo)
  );

  // reference: selection by repeated maximum, descending
  function automatic logic [4*W-1:0] ref_sort(input logic [W-1:0] a, b, c, d);
    logic [W-1:0] v [4];
    logic [W-1:0] t;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 4; j++)
        if (v[j] > v[i]) begin t = v[i]; v[i] = v[j]; v[j] = t; end
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic check(input string req, input logic [4*W-1:0] exp);
    applied++;
    if ({o_hi, o_mh, o_ml, o_lo} !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, {o_hi, o_mh, o_ml, o_lo}, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, b, c, d);
    @(negedge clk);
    i0 = a; i1 = b; i2 = c; i3 = d;
  endtask

  task automatic one_set(input string req, input logic [W-1:0] a, b, c, d);
    drive(a, b, c, d);
    @(negedge clk);
    @(negedge clk);
    check(req, ref_sort(a, b, c, d));
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    i0 = 4'd9; i1 = 4'd3; i2 = 4'd12; i3 = 4'd5;
    repeat (3) @(negedge clk);
    check("R4 outputs zero under reset", '0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 first result after release is zero set", '0);
  endtask

  task automatic t_latency();
    one_set("R1 settle", 4'd1, 4'd2, 4'd3, 4'd4);
    drive(4'd10, 4'd0, 4'd7, 4'd13);
    @(negedge clk);
    check("R1 old result held one edge", ref_sort(4'd1, 4'd2, 4'd3, 4'd4));
    @(negedge clk);
    check("R1 new result after second edge", ref_sort(4'd10, 4'd0, 4'd7, 4'd13));
  endtask

  task automatic t_orders();
    one_set("R2 ascending in", 4'd2, 4'd5, 4'd9, 4'd14);
    one_set("R2 descending in", 4'd14, 4'd9, 4'd5, 4'd2);
    one_set("R3 scrambled", 4'd6, 4'd11, 4'd1, 4'd8);
    one_set("R5 ripple 7 vs 8", 4'd7, 4'd8, 4'd7, 4'd8);
    one_set("R5 ripple 8 vs 7", 4'd8, 4'd7, 4'd0, 4'd15);
  endtask

  task automatic t_ties();
    one_set("R6 all equal", 4'd6, 4'd6, 4'd6, 4'd6);
    one_set("R6 two pairs", 4'd3, 4'd9, 4'd3, 4'd9);
    one_set("R3 triple duplicate", 4'd4, 4'd4, 4'd11, 4'd4);
  endtask

  task automatic t_extremes();
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] v [4];
      for (int k = 0; k < 4; k++) v[k] = W'(k + 5);
      v[p] = TOP;
      v[(p + 1) % 4] = '0;
      one_set("R8 extremes rotated", v[0], v[1], v[2], v[3]);
    end
    one_set("R8 all zero", '0, '0, '0, '0);
    one_set("R8 all max", TOP, TOP, TOP, TOP);
  endtask

  task automatic t_stream();
    logic [4*W-1:0] hist [2];
    logic [W-1:0] a, b, c, d;
    for (int n = 0; n < 40; n++) begin
      a = W'(n * 7 + 3); b = W'(n * 5 + 11); c = W'(n * 3); d = W'(15 - n);
      @(negedge clk);
      if (n >= 2) check("R7 back-to-back", hist[n % 2]);
      i0 = a; i1 = b; i2 = c; i3 = d;
      hist[n % 2] = ref_sort(a, b, c, d);
    end
  endtask

  task automatic t_mid_reset();
    drive(4'd9, 4'd1, 4'd14, 4'd2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R4 reset mid-stream clears", '0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 no stale data after release", '0);
    @(negedge clk);
    check("R4 resumes with held inputs", ref_sort(4'd9, 4'd1, 4'd14, 4'd2));
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_orders();
    t_ties();
    t_extremes();
    t_stream();
    t_mid_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    applied++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule